// File: doc/BRIEF.md
# Legacy Pin Interrupt Gate with Shared-Line Counters

This block handles the four level-sensitive interrupt pins of one bus function. It registers each pin's level and keeps a 16-bit command word that has a writable interrupt-disable bit. It also reports a status word whose interrupt bit is set whenever any registered pin is high. Each pin is routed to one of four shared interrupt lines. The route is a rotation by the function's device number: line = (pin + DEV_NUM) mod 4.

Each shared line has a small up/down counter. A line is driven while its counter is nonzero, so several contributors can share one line. The disable bit only blocks what goes out; the pin states inside the block are kept. When software sets the disable bit, the block takes back from the counters exactly the pins that are high at that moment. When software clears the bit, the block adds those pins back.

Top module: `intx_gate`

## Requirements
- R1: While reset is low and on the first cycle after it, the command word, the status word, every line counter and every line output are zero.
- R2: A write with `cmd_we` high stores `cmd_wdata` ANDed with the writable mask 16'h0407 into the command word, where it is visible on the next cycle. Bit 10 is the interrupt-disable bit. Other bits always read zero, and the word holds its value when no write occurs.
- R3: Bit 3 of `status_word` is 1 exactly when any registered pin level is high, one cycle after the pin input changes, whatever the disable bit is. All other status bits read zero.
- R4: With interrupts enabled, a pin that rises adds 1 to the counter of line (pin + DEV_NUM) mod 4 on the next cycle, and a pin that falls takes 1 away.
- R5: With the disable bit set, pin changes leave every counter unchanged.
- R6: A write that sets the disable bit subtracts 1 from the mapped counter of every pin that is currently high, so a single function's counters all become zero.
- R7: A write that clears the disable bit adds 1 to the mapped counter of every pin that is currently high.
- R8: When a disable-bit change and a pin change happen in the same cycle, the block applies the command change first and then the pin change. Each counter ends equal to the number of mapped high pins under the new disable bit.
- R9: `line_assert[l]` is 1 exactly when the counter of line l is nonzero. Counter l sits at bits [l*3 +: 3] of `line_count`.
- R10: A cycle with no pin change and no change of the disable bit leaves every counter unchanged. This includes writes that touch only other command bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 4 | Level of interrupt pins 0..3 |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word write data |
| cmd_word | output | 16 | Current command word |
| status_word | output | 16 | Status word, interrupt bit at position 3 |
| line_assert | output | 4 | Shared line drive, one per line |
| line_count | output | 12 | Line counters, 3 bits each, line 0 lowest |

## Verification
The bench builds the block with DEV_NUM = 1 rather than 0. Each pin then lands on a line with a different index, so a routing that ignores the rotation, or rotates the wrong way, shows up in the counters. The default 3-bit counters and the 0x0407 mask are kept. This brings into reach the full-mask write that leaves the block disabled, and the same-cycle cases where a disable or enable meets a rising or falling pin.

// File: rtl/intx_gate_pkg.sv
package intx_gate_pkg;

    localparam int NUM_PINS = 4;

    // Shared line reached by a pin for a given device number.
    function automatic int line_of(input int pin, input int dev);
        return (pin + dev) % NUM_PINS;
    endfunction

    // Bit set of pins routed onto one line.
    function automatic logic [NUM_PINS-1:0] pins_on_line(input int line, input int dev);
        logic [NUM_PINS-1:0] m;
        m = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (line_of(p, dev) == line) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/intx_cmd_reg.sv
module intx_cmd_reg #(
    parameter int          CMD_W   = 16,
    parameter logic [15:0] WMASK   = 16'h0407,
    parameter int          DIS_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic             dis_next,
    output logic             dis_flip
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.cmd = wdata & CMD_W'(WMASK);
        dis_next = st_d.cmd[DIS_BIT];
        dis_flip = st_d.cmd[DIS_BIT] ^ st_q.cmd[DIS_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_q = st_q.cmd;

    AST_CMD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_W'(WMASK)) == '0); // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cmd_q)); // R2

endmodule

// File: rtl/intx_pin_track.sv
module intx_pin_track #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall,
    output logic         any_q
);

    typedef struct packed {
        logic [N-1:0] pins;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d.pins = pin_in;
        rise      = pin_in & ~st_q.pins;
        fall      = ~pin_in & st_q.pins;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_q = st_q.pins;
    assign any_q = |st_q.pins;

    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_q == $past(pin_in)); // R3
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & fall) == '0); // R4

endmodule

// File: rtl/intx_line_ctr.sv
module intx_line_ctr
    import intx_gate_pkg::*;
#(
    parameter int N       = 4,
    parameter int CNT_W   = 3,
    parameter int DEV_NUM = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pin_q,
    input  logic [N-1:0]   rise,
    input  logic [N-1:0]   fall,
    input  logic           dis_next,
    input  logic           dis_flip,
    output logic [N*CNT_W-1:0] cnt_flat,
    output logic [N-1:0]   line_on
);

    typedef struct packed {
        logic [N-1:0][CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [N-1:0][CNT_W-1:0] delta;

    always_comb begin
        delta = '0;
        for (int p = 0; p < N; p++) begin
            // Command update first: withdraw or restore held pins.
            if (dis_flip && pin_q[p]) begin
                if (dis_next) delta[line_of(p, DEV_NUM)] = delta[line_of(p, DEV_NUM)] - CNT_W'(1);
                else          delta[line_of(p, DEV_NUM)] = delta[line_of(p, DEV_NUM)] + CNT_W'(1);
            end
            // Pin change second, under the new disable bit.
            if (!dis_next) begin
                if (rise[p]) delta[line_of(p, DEV_NUM)] = delta[line_of(p, DEV_NUM)] + CNT_W'(1);
                if (fall[p]) delta[line_of(p, DEV_NUM)] = delta[line_of(p, DEV_NUM)] - CNT_W'(1);
            end
        end
        st_d = st_q;
        for (int l = 0; l < N; l++) begin
            st_d.cnt[l] = st_q.cnt[l] + delta[l];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign cnt_flat[g*CNT_W +: CNT_W] = st_q.cnt[g];
        assign line_on[g]                 = |st_q.cnt[g];

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            int'(st_q.cnt[g]) <= N); // R4
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == '0 && fall == '0 && !dis_flip) |=> $stable(cnt_flat)); // R10
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_next && !dis_flip) |=> $stable(cnt_flat)); // R5

endmodule

// File: rtl/intx_gate.sv
module intx_gate
    import intx_gate_pkg::*;
#(
    parameter int          DEV_NUM   = 0,
    parameter int          CNT_W     = 3,
    parameter logic [15:0] CMD_WMASK = 16'h0407,
    parameter int          DIS_BIT   = 10,
    parameter int          STAT_BIT  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  pin_in,
    input  logic        cmd_we,
    input  logic [15:0] cmd_wdata,
    output logic [15:0] cmd_word,
    output logic [15:0] status_word,
    output logic [3:0]  line_assert,
    output logic [11:0] line_count
);

    localparam int N = NUM_PINS;

    logic [N-1:0] pin_q, rise, fall;
    logic         any_q, dis_next, dis_flip;
    logic [N*CNT_W-1:0] cnt_flat;

    intx_cmd_reg #(.CMD_W(16), .WMASK(CMD_WMASK), .DIS_BIT(DIS_BIT)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(cmd_we), .wdata(cmd_wdata),
        .cmd_q(cmd_word), .dis_next(dis_next), .dis_flip(dis_flip)
    );

    intx_pin_track #(.N(N)) u_pins (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_q(pin_q), .rise(rise), .fall(fall), .any_q(any_q)
    );

    intx_line_ctr #(.N(N), .CNT_W(CNT_W), .DEV_NUM(DEV_NUM)) u_ctr (
        .clk(clk), .rst_n(rst_n), .pin_q(pin_q), .rise(rise), .fall(fall),
        .dis_next(dis_next), .dis_flip(dis_flip),
        .cnt_flat(cnt_flat), .line_on(line_assert)
    );

    always_comb begin
        status_word           = '0;
        status_word[STAT_BIT] = any_q;
    end

    assign line_count = 12'(cnt_flat);

    for (genvar g = 0; g < N; g++) begin : g_chk
        localparam logic [N-1:0] LMASK = pins_on_line(g, DEV_NUM);
        AST_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cnt_flat[g*CNT_W +: CNT_W]) ==
            (cmd_word[DIS_BIT] ? 0 : $countones(pin_q & LMASK))); // R8
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_word[DIS_BIT] |-> line_assert == '0); // R6

endmodule

// File: tb/intx_gate_test.sv
module intx_gate_test;

    localparam int DEV = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = '0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_word, status_word;
    logic [3:0]  line_assert;
    logic [11:0] line_count;

    always #5 clk = ~clk;

    intx_gate #(.DEV_NUM(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmd_we(cmd_we),
        .cmd_wdata(cmd_wdata), .cmd_word(cmd_word), .status_word(status_word),
        .line_assert(line_assert), .line_count(line_count)
    );

    typedef struct {
        logic [15:0] cmd;
        logic [15:0] stat;
        logic [11:0] cnt;
        logic [3:0]  lines;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [3:0]  m_pins = '0;
    logic [15:0] m_cmd = '0;

    function automatic exp_t model(input string tag);
        exp_t e;
        e.cmd   = m_cmd;
        e.stat  = {12'd0, |m_pins, 3'd0};
        e.cnt   = '0;
        e.lines = '0;
        for (int p = 0; p < 4; p++) begin
            if (m_pins[p] && !m_cmd[10]) begin
                e.cnt[((p + DEV) % 4)*3 +: 3] = e.cnt[((p + DEV) % 4)*3 +: 3] + 3'd1;
            end
        end
        for (int l = 0; l < 4; l++) e.lines[l] = (e.cnt[l*3 +: 3] != 3'd0);
        e.tag = tag;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        n_chk += 4;
        if (cmd_word !== e.cmd) begin
            n_bad++; $display("FAIL %s cmd_word act=%h exp=%h", e.tag, cmd_word, e.cmd);
        end
        if (status_word !== e.stat) begin
            n_bad++; $display("FAIL %s status_word act=%h exp=%h", e.tag, status_word, e.stat);
        end
        if (line_count !== e.cnt) begin
            n_bad++; $display("FAIL %s line_count act=%h exp=%h", e.tag, line_count, e.cnt);
        end
        if (line_assert !== e.lines) begin
            n_bad++; $display("FAIL %s R9 line_assert act=%b exp=%b", e.tag, line_assert, e.lines);
        end
    endtask

    task automatic drive(input logic [3:0] p, input logic we, input logic [15:0] wd, input string tag);
        @(negedge clk);
        pin_in    = p;
        cmd_we    = we;
        cmd_wdata = wd;
        if (we) m_cmd = wd & 16'h0407;
        m_pins = p;
        sb.push_back(model(tag));
    endtask

    // Monitor: compare one expected item per clock, after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare(model("R1 during reset"));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare(model("R1 after reset"));

        drive(4'b0000, 1'b1, 16'hFFFF, "R2 full write masked");
        drive(4'b0000, 1'b1, 16'h0007, "R2 enable write");
        drive(4'b0001, 1'b0, 16'h0000, "R4 R3 pin0 rise to line1");
        drive(4'b0101, 1'b0, 16'h0000, "R4 pin2 rise to line3");
        drive(4'b0101, 1'b0, 16'hDEAD, "R10 R2 idle hold");
        drive(4'b0101, 1'b1, 16'h0003, "R10 write other bits");
        drive(4'b0101, 1'b1, 16'h0400, "R6 disable withdraws");
        drive(4'b0110, 1'b0, 16'h0000, "R5 R3 pin change while disabled");
        drive(4'b0110, 1'b1, 16'h0000, "R7 enable restores");
        drive(4'b1110, 1'b1, 16'h0400, "R8 disable with pin3 rise");
        drive(4'b1100, 1'b1, 16'h0000, "R8 enable with pin1 fall");
        drive(4'b1101, 1'b0, 16'h0000, "R4 pin0 rise shares rotation");
        drive(4'b0000, 1'b0, 16'h0000, "R4 R3 all fall");
        drive(4'b1111, 1'b0, 16'h0000, "R4 all rise");
        drive(4'b1111, 1'b0, 16'h0000, "R10 hold all high");
        drive(4'b0000, 1'b1, 16'h0400, "R8 disable with all fall");
        drive(4'b0000, 1'b0, 16'h0000, "R3 status clear");
        repeat (4) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule